// File: doc/BRIEF.md
# Job Slot Command Register Block

This block is the register file and control for a single job slot of a job-dispatch engine. Host software fills a set of staging registers through a 32-bit register bus: a 64-bit head pointer, a 64-bit affinity mask and a 32-bit configuration word. It then launches the job by writing the START code to the next-command register. On that write the staged values move into the active registers and every staging register returns to zero. The slot then runs a stub job. The stub finishes a fixed number of cycles later, as set by a parameter. When it finishes, the slot reports success or failure to the job-control logic through single-cycle pulses that carry the slot number.

Stop requests go through a separate immediate-command register. Two stop codes always act. Four others apply only when the chain flag of the active configuration matches the variant, clear for one pair and set for the other. A stop that acts on a running job ends it with a stopped status and a done pulse. The START code is illegal on the immediate register. It raises an error pulse and does not launch a job.

Top module: `jsr_slot`

Register word addresses: 0 immediate command (reads the active command), 1 next command, 2 status, 3 active config, 4 next config, 5/6 active head LO/HI, 7/8 active tail LO/HI, 9/10 active affinity LO/HI, 11/12 next head LO/HI, 13/14 next affinity LO/HI, 15 unused (reads zero).

Command codes: 0 NOP, 1 START, 2 SOFT_STOP, 3 HARD_STOP, 4 SOFT_STOP_0, 5 HARD_STOP_0, 6 SOFT_STOP_1, 7 HARD_STOP_1.

Status values: idle 0x0, active 0x2, done 0x1, fault 0x1000_0001, soft-stopped 0x101, hard-stopped 0x201.

Config bits: bit 0 makes the stub job fail, and bit 8 is the chain flag.

## Requirements
- R1: After reset, every address reads zero, and job_done_o, job_failed_o, cmd_err_o and evt_slot_o are zero.
- R2: Writes to addresses 4, 11, 12, 13 and 14 store the whole 32-bit word, and the word reads back at the same address. Read data is combinational from bus_addr.
- R3: A write of the value 1 (START) to address 1 copies next head into both active head and active tail, next affinity into active affinity and next config into active config, and sets address 0 to 1. The new values are visible in the cycle after the write.
- R4: That same START write clears next head, next affinity, next config and next command to zero, and sets status to 0x2.
- R5: A write of any value other than 1 to address 1 is stored there and launches nothing.
- R6: If no stop arrives, a job that launched at clock edge E finishes at edge E+JOB_CYCLES. At that edge status becomes 0x1, and job_done_o is high for one cycle with evt_slot_o equal to SLOT_ID. evt_slot_o is zero while no pulse is present.
- R7: If bit 0 of the active config is set, the job instead finishes with status 0x1000_0001 and a one-cycle job_failed_o pulse carrying SLOT_ID. In that case job_done_o stays low.
- R8: Writing 1 to address 0 raises cmd_err_o for one cycle and changes no register.
- R9: Codes 2 and 3 written to address 0 while a job runs end it. Code 2 sets status 0x101 and code 3 sets 0x201. Each gives a one-cycle job_done_o pulse, and no completion follows.
- R10: Codes 4 and 5 act only when bit 8 of the active config is clear, and codes 6 and 7 act only when it is set. Codes 4 and 6 are soft stops and codes 5 and 7 are hard stops.
- R11: A stop code written while no job runs has no effect. Codes 8 and above written to address 0 have no effect. Writes to addresses 2, 3, 5 to 10 and 15 have no effect.
- R12: A launch or stop that lands on the finishing edge takes priority over completion. A stop gives its stopped status and a single done pulse. A launch restarts the job and gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data at bus_addr |
| job_done_o | output | 1 | Job finished or stopped without fault |
| job_failed_o | output | 1 | Job finished with fault class |
| evt_slot_o | output | ID_W | Slot number during a pulse, else zero |
| cmd_err_o | output | 1 | Illegal START on immediate command |

## Verification
The hardest case to reach is a stop or relaunch written on exactly the edge at which the stub job would finish, because it needs a launch followed by precisely JOB_CYCLES-1 idle cycles. Directed sequences count those cycles out for both the stop and the relaunch. The chain-qualified stops also need the active config to hold the right flag, so directed cases launch jobs with the flag set and with it clear. Each case then tries both variant pairs. Long random runs mix launches, stops and staging writes, which also reach these collisions by chance.

// File: rtl/jsr_pkg.sv
package jsr_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CMD      = 4'd0;
    localparam logic [ADDR_W-1:0] A_CMD_NEXT = 4'd1;
    localparam logic [ADDR_W-1:0] A_STATUS   = 4'd2;
    localparam logic [ADDR_W-1:0] A_CFG      = 4'd3;
    localparam logic [ADDR_W-1:0] A_CFG_NEXT = 4'd4;
    localparam logic [ADDR_W-1:0] A_HEAD_LO  = 4'd5;
    localparam logic [ADDR_W-1:0] A_HEAD_HI  = 4'd6;
    localparam logic [ADDR_W-1:0] A_TAIL_LO  = 4'd7;
    localparam logic [ADDR_W-1:0] A_TAIL_HI  = 4'd8;
    localparam logic [ADDR_W-1:0] A_AFF_LO   = 4'd9;
    localparam logic [ADDR_W-1:0] A_AFF_HI   = 4'd10;
    localparam logic [ADDR_W-1:0] A_HNX_LO   = 4'd11;
    localparam logic [ADDR_W-1:0] A_HNX_HI   = 4'd12;
    localparam logic [ADDR_W-1:0] A_ANX_LO   = 4'd13;
    localparam logic [ADDR_W-1:0] A_ANX_HI   = 4'd14;

    typedef enum logic [2:0] {
        CMD_NOP      = 3'd0,
        CMD_START    = 3'd1,
        CMD_SSTOP    = 3'd2,
        CMD_HSTOP    = 3'd3,
        CMD_SSTOP_C0 = 3'd4,
        CMD_HSTOP_C0 = 3'd5,
        CMD_SSTOP_C1 = 3'd6,
        CMD_HSTOP_C1 = 3'd7
    } cmd_e;

    localparam logic [REG_W-1:0] ST_IDLE   = 32'h0000_0000;
    localparam logic [REG_W-1:0] ST_ACTIVE = 32'h0000_0002;
    localparam logic [REG_W-1:0] ST_DONE   = 32'h0000_0001;
    localparam logic [REG_W-1:0] ST_FAULT  = 32'h1000_0001;
    localparam logic [REG_W-1:0] ST_SOFTED = 32'h0000_0101;
    localparam logic [REG_W-1:0] ST_HARDED = 32'h0000_0201;

    localparam int CFG_FAULT_BIT = 0;
    localparam int CFG_CHAIN_BIT = 8;
endpackage

// File: rtl/jsr_cmd_decode.sv
module jsr_cmd_decode
    import jsr_pkg::*;
(
    input  logic [REG_W-1:0] code_i,
    input  logic             chain_i,
    output logic             start_o,
    output logic             stop_o,
    output logic             hard_o
);
    logic in_range;
    cmd_e op;

    always_comb begin
        in_range = (code_i[REG_W-1:3] == '0);
        op       = cmd_e'(code_i[2:0]);
        start_o  = 1'b0;
        stop_o   = 1'b0;
        hard_o   = 1'b0;
        if (in_range) begin
            case (op)
                CMD_START:    start_o = 1'b1;
                CMD_SSTOP:    stop_o  = 1'b1;
                CMD_HSTOP:    begin stop_o = 1'b1; hard_o = 1'b1; end
                CMD_SSTOP_C0: stop_o  = !chain_i;
                CMD_HSTOP_C0: begin stop_o = !chain_i; hard_o = 1'b1; end
                CMD_SSTOP_C1: stop_o  = chain_i;
                CMD_HSTOP_C1: begin stop_o = chain_i; hard_o = 1'b1; end
                default:      ;
            endcase
        end
    end
endmodule

// File: rtl/jsr_job_stub.sv
module jsr_job_stub #(
    parameter int unsigned JOB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic kill_i,
    output logic busy_o,
    output logic finish_o
);
    localparam int CNT_W = $clog2(JOB_CYCLES + 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } stub_t;

    stub_t st_d, st_q;

    assign busy_o   = st_q.run;
    assign finish_o = st_q.run && (st_q.cnt == CNT_W'(1));

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.run = 1'b1;
            st_d.cnt = CNT_W'(JOB_CYCLES);
        end else if (kill_i || finish_o) begin
            st_d.run = 1'b0;
        end else if (st_q.run) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (st_q.cnt >= CNT_W'(1) && st_q.cnt <= CNT_W'(JOB_CYCLES))); // R6
    AST_FINISH_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (finish_o && !start_i) |=> !busy_o); // R6
endmodule

// File: rtl/jsr_slot.sv
module jsr_slot
    import jsr_pkg::*;
#(
    parameter int unsigned SLOT_ID    = 0,
    parameter int unsigned ID_W       = 4,
    parameter int unsigned JOB_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              job_done_o,
    output logic              job_failed_o,
    output logic [ID_W-1:0]   evt_slot_o,
    output logic              cmd_err_o
);
    localparam int HALF = REG_W;
    localparam int WIDE = 2 * REG_W;

    typedef struct packed {
        logic [REG_W-1:0] cmd;
        logic [REG_W-1:0] cmd_next;
        logic [REG_W-1:0] status;
        logic [REG_W-1:0] cfg;
        logic [REG_W-1:0] cfg_next;
        logic [WIDE-1:0]  head;
        logic [WIDE-1:0]  tail;
        logic [WIDE-1:0]  aff;
        logic [WIDE-1:0]  hnext;
        logic [WIDE-1:0]  anext;
        logic             done_p;
        logic             fail_p;
        logic             err_p;
    } slot_t;

    slot_t st_d, st_q;

    logic dec_start, dec_stop, dec_hard;
    logic wr_cmd, wr_next, launch, stop_now;
    logic busy, finish;

    jsr_cmd_decode u_dec (
        .code_i  (bus_wdata),
        .chain_i (st_q.cfg[CFG_CHAIN_BIT]),
        .start_o (dec_start),
        .stop_o  (dec_stop),
        .hard_o  (dec_hard)
    );

    jsr_job_stub #(.JOB_CYCLES(JOB_CYCLES)) u_stub (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (launch),
        .kill_i   (stop_now),
        .busy_o   (busy),
        .finish_o (finish)
    );

    always_comb begin
        wr_cmd   = bus_we && (bus_addr == A_CMD);
        wr_next  = bus_we && (bus_addr == A_CMD_NEXT);
        launch   = wr_next && dec_start;
        stop_now = wr_cmd && dec_stop && busy;
    end

    always_comb begin
        st_d        = st_q;
        st_d.done_p = 1'b0;
        st_d.fail_p = 1'b0;
        st_d.err_p  = wr_cmd && dec_start;

        if (bus_we) begin
            case (bus_addr)
                A_CMD_NEXT: if (!launch) st_d.cmd_next = bus_wdata;
                A_CFG_NEXT: st_d.cfg_next = bus_wdata;
                A_HNX_LO:   st_d.hnext[HALF-1:0]    = bus_wdata;
                A_HNX_HI:   st_d.hnext[WIDE-1:HALF] = bus_wdata;
                A_ANX_LO:   st_d.anext[HALF-1:0]    = bus_wdata;
                A_ANX_HI:   st_d.anext[WIDE-1:HALF] = bus_wdata;
                default:    ;
            endcase
        end

        if (launch) begin
            st_d.head     = st_q.hnext;
            st_d.tail     = st_q.hnext;
            st_d.aff      = st_q.anext;
            st_d.cfg      = st_q.cfg_next;
            st_d.cmd      = REG_W'(CMD_START);
            st_d.hnext    = '0;
            st_d.anext    = '0;
            st_d.cfg_next = '0;
            st_d.cmd_next = '0;
            st_d.status   = ST_ACTIVE;
        end else if (stop_now) begin
            st_d.status = dec_hard ? ST_HARDED : ST_SOFTED;
            st_d.done_p = 1'b1;
        end else if (finish) begin
            if (st_q.cfg[CFG_FAULT_BIT]) begin
                st_d.status = ST_FAULT;
                st_d.fail_p = 1'b1;
            end else begin
                st_d.status = ST_DONE;
                st_d.done_p = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (bus_addr)
            A_CMD:      bus_rdata = st_q.cmd;
            A_CMD_NEXT: bus_rdata = st_q.cmd_next;
            A_STATUS:   bus_rdata = st_q.status;
            A_CFG:      bus_rdata = st_q.cfg;
            A_CFG_NEXT: bus_rdata = st_q.cfg_next;
            A_HEAD_LO:  bus_rdata = st_q.head[HALF-1:0];
            A_HEAD_HI:  bus_rdata = st_q.head[WIDE-1:HALF];
            A_TAIL_LO:  bus_rdata = st_q.tail[HALF-1:0];
            A_TAIL_HI:  bus_rdata = st_q.tail[WIDE-1:HALF];
            A_AFF_LO:   bus_rdata = st_q.aff[HALF-1:0];
            A_AFF_HI:   bus_rdata = st_q.aff[WIDE-1:HALF];
            A_HNX_LO:   bus_rdata = st_q.hnext[HALF-1:0];
            A_HNX_HI:   bus_rdata = st_q.hnext[WIDE-1:HALF];
            A_ANX_LO:   bus_rdata = st_q.anext[HALF-1:0];
            A_ANX_HI:   bus_rdata = st_q.anext[WIDE-1:HALF];
            default:    bus_rdata = '0;
        endcase
    end

    assign job_done_o   = st_q.done_p;
    assign job_failed_o = st_q.fail_p;
    assign cmd_err_o    = st_q.err_p;
    assign evt_slot_o   = (st_q.done_p || st_q.fail_p) ? ID_W'(SLOT_ID) : '0;

    AST_LAUNCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CMD_NEXT && bus_wdata == REG_W'(CMD_START)) |=>
        (st_q.hnext == '0 && st_q.anext == '0 && st_q.cfg_next == '0 &&
         st_q.cmd_next == '0 && st_q.status == ST_ACTIVE)); // R4
    AST_HEAD_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CMD_NEXT && bus_wdata == REG_W'(CMD_START)) |=>
        (st_q.head == st_q.tail && st_q.head == $past(st_q.hnext))); // R3
    AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err_o |-> ($stable(st_q.cfg) && $stable(st_q.head) && $stable(st_q.cmd))); // R8
    AST_IDLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CMD && !busy) |=> ($stable(st_q.status) && !job_done_o)); // R11
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(job_done_o && job_failed_o)); // R7
endmodule

// File: tb/jsr_slot_bench.sv
module jsr_slot_bench;
    localparam int CLK_PERIOD = 10;
    localparam int J          = 6;
    localparam int SID        = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        job_done_o, job_failed_o, cmd_err_o;
    logic [3:0]  evt_slot_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] m_r [16];
    bit          m_run;
    int          m_cnt;
    bit          m_done, m_fail, m_err;

    jsr_slot #(.SLOT_ID(SID), .ID_W(4), .JOB_CYCLES(J)) u_jsr_slot (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .job_done_o(job_done_o),
        .job_failed_o(job_failed_o), .evt_slot_o(evt_slot_o), .cmd_err_o(cmd_err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit stop_acts(input logic [31:0] c, input bit chain);
        if (c == 2 || c == 3) return 1;
        if (c == 4 || c == 5) return !chain;
        if (c == 6 || c == 7) return chain;
        return 0;
    endfunction

    task automatic model_step(input logic we, input logic [3:0] a, input logic [31:0] d);
        bit fin, started, stopped;
        fin = m_run && (m_cnt == 1);
        started = 0; stopped = 0;
        m_done = 0; m_fail = 0; m_err = 0;
        if (we) begin
            case (a)
                4'd0: begin
                    if (d == 1) m_err = 1;
                    else if (m_run && stop_acts(d, m_r[3][8])) begin
                        m_r[2] = d[0] ? 32'h201 : 32'h101;
                        m_done = 1; m_run = 0; stopped = 1;
                    end
                end
                4'd1: begin
                    if (d == 1) begin
                        m_r[0] = 1; m_r[3] = m_r[4];
                        m_r[5] = m_r[11]; m_r[6] = m_r[12];
                        m_r[7] = m_r[11]; m_r[8] = m_r[12];
                        m_r[9] = m_r[13]; m_r[10] = m_r[14];
                        m_r[1] = 0; m_r[4] = 0;
                        m_r[11] = 0; m_r[12] = 0; m_r[13] = 0; m_r[14] = 0;
                        m_r[2] = 32'h2; m_run = 1; m_cnt = J; started = 1;
                    end else m_r[1] = d;
                end
                4'd4, 4'd11, 4'd12, 4'd13, 4'd14: m_r[a] = d;
                default: ;
            endcase
        end
        if (!started && !stopped) begin
            if (fin) begin
                if (m_r[3][0]) begin m_r[2] = 32'h1000_0001; m_fail = 1; end
                else begin m_r[2] = 32'h1; m_done = 1; end
                m_run = 0;
            end else if (m_run) m_cnt--;
        end
    endtask

    task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] d, input string tag);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        chk(tag, bus_rdata, m_r[a]);
        model_step(we, a, d);
        @(posedge clk);
        #1;
        chk("R6 done pulse", {31'd0, job_done_o}, {31'd0, m_done});
        chk("R7 failed pulse", {31'd0, job_failed_o}, {31'd0, m_fail});
        chk("R8 error pulse", {31'd0, cmd_err_o}, {31'd0, m_err});
        chk("R6 slot id", {28'd0, evt_slot_o}, (m_done || m_fail) ? SID : 0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
        cyc(1'b1, a, d, tag);
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        cyc(1'b0, a, 32'h0, tag);
    endtask

    task automatic rd_all(input string tag);
        for (int i = 0; i < 16; i++) rd(4'(i), tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) rd(4'd2, "R6 status");
    endtask

    task automatic stage(input logic [31:0] cfg);
        wr(4'd11, $urandom, "R2 stage");
        wr(4'd12, $urandom, "R2 stage");
        wr(4'd13, $urandom, "R2 stage");
        wr(4'd14, $urandom, "R2 stage");
        wr(4'd4, cfg, "R2 stage");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) m_r[i] = '0;
        m_run = 0; m_cnt = 0; m_done = 0; m_fail = 0; m_err = 0;
        repeat (4) @(posedge clk);
        #1;
        chk("R1 done after reset", {31'd0, job_done_o}, 0);
        chk("R1 err after reset", {31'd0, cmd_err_o}, 0);
        rst_n = 1'b1;
        rd_all("R1 reset read");

        // R2 / R5 staging and non-start next command
        stage(32'h0);
        wr(4'd1, 32'd5, "R5 next cmd");
        rd_all("R2 R5 readback");

        // R3 R4 R6 normal job
        wr(4'd1, 32'd1, "R3 launch");
        rd_all("R3 R4 after launch");
        idle(J + 2);

        // R8 illegal start, R11 idle stops and big codes and ignored writes
        wr(4'd0, 32'd1, "R8 imm start");
        wr(4'd0, 32'd2, "R11 idle stop");
        wr(4'd0, 32'd3, "R11 idle stop");
        wr(4'd2, 32'hFFFF_FFFF, "R11 ro write");
        wr(4'd5, 32'h1234_5678, "R11 ro write");
        wr(4'd15, 32'h1, "R11 ro write");
        rd_all("R11 after ignored");

        // R7 fault job
        stage(32'h1);
        wr(4'd1, 32'd1, "R7 launch");
        idle(J + 1);

        // R9 soft and hard stop
        stage(32'h0);
        wr(4'd1, 32'd1, "R9 launch");
        idle(2);
        wr(4'd0, 32'd9, "R11 big code");
        wr(4'd0, 32'd8, "R11 big code");
        wr(4'd0, 32'd2, "R9 soft stop");
        idle(J + 1);
        stage(32'h0);
        wr(4'd1, 32'd1, "R9 launch");
        wr(4'd0, 32'd1, "R8 imm start running");
        wr(4'd0, 32'd3, "R9 hard stop");
        idle(J + 1);

        // R10 chain set
        stage(32'h100);
        wr(4'd1, 32'd1, "R10 launch");
        wr(4'd0, 32'd4, "R10 c0 ignored");
        wr(4'd0, 32'd5, "R10 c0 ignored");
        wr(4'd0, 32'd6, "R10 c1 soft");
        idle(J);
        stage(32'h100);
        wr(4'd1, 32'd1, "R10 launch");
        wr(4'd0, 32'd7, "R10 c1 hard");
        idle(2);
        // R10 chain clear
        stage(32'h0);
        wr(4'd1, 32'd1, "R10 launch");
        wr(4'd0, 32'd6, "R10 c1 ignored");
        wr(4'd0, 32'd7, "R10 c1 ignored");
        wr(4'd0, 32'd5, "R10 c0 hard");
        idle(J);
        stage(32'h0);
        wr(4'd1, 32'd1, "R10 launch");
        wr(4'd0, 32'd4, "R10 c0 soft");
        idle(2);

        // R12 stop on the finishing edge
        stage(32'h0);
        wr(4'd1, 32'd1, "R12 launch");
        idle(J - 1);
        wr(4'd0, 32'd3, "R12 stop at finish");
        idle(J + 1);
        // R12 relaunch on the finishing edge
        stage(32'h1);
        wr(4'd1, 32'd1, "R12 launch");
        idle(J - 1);
        wr(4'd1, 32'd1, "R12 relaunch at finish");
        idle(J + 1);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int unsigned r;
            r = $urandom % 16;
            if (r < 4) begin
                int unsigned k;
                k = $urandom % 5;
                wr((k == 0) ? 4'd4 : 4'(10 + k), $urandom, "R2 random stage");
            end else if (r < 6) wr(4'd1, 32'd1, "R3 random launch");
            else if (r == 6) wr(4'd1, $urandom % 4, "R5 random next");
            else if (r < 10) wr(4'd0, $urandom % 10, "R9 R10 random cmd");
            else if (r == 10) wr(4'($urandom % 16), $urandom, "R11 random addr");
            else if (r == 11) wr(4'd0, $urandom, "R11 random big");
            else rd(4'($urandom % 16), "R2 random read");
        end
        idle(J + 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule